// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is a single input port of an on-chip network router that carries several virtual channels over one physical link. Each arriving flit names its virtual channel and carries a head flag and a tail flag. The flit is queued in that channel's own buffer. Every channel keeps a small state record: its pipeline phase, the output port chosen for its packet, and the downstream virtual channel it was granted.

The packet's head flit is the only flit that requests a route and then a downstream virtual channel. When both are held, the channel competes for the switch one flit per grant. Body and tail flits reuse the stored port and downstream channel. When the tail flit leaves, the channel goes back to idle and releases its allocation.

The route function, the two allocators and the crossbar sit outside the block. They are reached through request and grant signals. Channels progress independently, so one stalled packet does not hold back another channel on the same link.

Top module: `vc_input_unit`

## Requirements
- R1: After reset every channel is idle and empty: `in_full`, `in_err`, `rc_req_valid`, `va_req`, `sa_req` and `out_valid` are all 0.
- R2: A flit with `in_valid`=1 is appended to the buffer of channel `in_vc`. `in_head`=1 marks a head flit, `in_tail`=1 marks a tail flit, and both set together mark a single-flit packet. `in_full[v]` is 1 exactly while channel v holds DEPTH flits.
- R3: A write to a full channel is dropped, and `in_err` is 1 for exactly the following cycle.
- R4: An idle channel whose oldest flit is a head raises a route request in the next cycle. With several such channels, the lowest index is presented on `rc_req_vc` with that head's payload on `rc_req_hdr`. When `rc_rsp_ready` is 1, `rc_rsp_port` is stored as the channel's output port.
- R5: After routing, the channel holds `va_req[v]` with its stored port on `va_port` until `va_gnt[v]`. At the grant it stores `va_gnt_ovc` as its downstream channel.
- R6: Only head flits cause a route request or a VC request. A channel that has both allocations raises `sa_req[v]` whenever it holds at least one flit.
- R7: On `sa_gnt[v]` with `sa_req[v]` set, the oldest flit of channel v leaves. In the next cycle `out_valid` is 1 with that flit's data and flags, the channel's stored port and its stored downstream channel. Flits of one channel leave in arrival order.
- R8: The departure of a tail flit, including a single-flit packet, returns the channel to idle. Its next head flit repeats the route and VC allocation steps.
- R9: A channel stalled in VC allocation does not block another channel's packet from crossing the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_vc | input | VC_W | Channel of incoming flit |
| in_head | input | 1 | Flit is a packet head |
| in_tail | input | 1 | Flit is a packet tail |
| in_data | input | DATA_W | Flit payload |
| in_full | output | NUM_VC | Per-channel buffer full (backpressure) |
| in_err | output | 1 | Write to a full channel seen last cycle |
| rc_req_valid | output | 1 | Route request |
| rc_req_vc | output | VC_W | Channel asking for a route |
| rc_req_hdr | output | DATA_W | Head payload for route computation |
| rc_rsp_ready | input | 1 | Route response accepted this cycle |
| rc_rsp_port | input | PORT_W | Computed output port |
| va_req | output | NUM_VC | Per-channel downstream VC request |
| va_port | output | NUM_VC*PORT_W | Output port of each requesting channel |
| va_gnt | input | NUM_VC | Per-channel downstream VC grant |
| va_gnt_ovc | input | OVC_W | Downstream VC given with the grant |
| sa_req | output | NUM_VC | Per-channel switch request |
| sa_gnt | input | NUM_VC | Per-channel switch grant, at most one set |
| out_valid | output | 1 | Flit on the switch output |
| out_head | output | 1 | Outgoing head flag |
| out_tail | output | 1 | Outgoing tail flag |
| out_data | output | DATA_W | Outgoing payload |
| out_port | output | PORT_W | Output port for the flit |
| out_ovc | output | OVC_W | Downstream VC for the flit |

## Verification
The bench builds the block with two channels of four flits each, an 8-bit payload and 2-bit port and VC fields. A buffer fills after four writes, so the dropped-write error is reached within a few cycles. The route is simply the low payload bits, so the expected port follows from each head. With two channels, one can be held in VC allocation while the other crosses the switch. The same setup also exercises lowest-index route arbitration when both channels wait on a stalled route responder.

// File: rtl/vcin_pkg.sv
package vcin_pkg;
    typedef enum logic [1:0] {
        VC_IDLE   = 2'd0,
        VC_ROUTE  = 2'd1,
        VC_VALLOC = 2'd2,
        VC_ACTIVE = 2'd3
    } vc_state_e;
endpackage

// File: rtl/vcin_fifo.sv
module vcin_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + PTR_W'(1);
        if (pop)  s_d.rd = (s_q.rd == LAST) ? '0 : s_q.rd + PTR_W'(1);
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wr] <= wdata;
    end

    assign rdata = mem_q[s_q.rd];
    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);

    // R2: occupancy never exceeds the buffer depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
    // R7: a flit only leaves a channel that holds one
    a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/vcin_vc_ctrl.sv
module vcin_vc_ctrl
    import vcin_pkg::*;
#(
    parameter int PORT_W = 2,
    parameter int OVC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              front_valid,
    input  logic              front_head,
    input  logic              front_tail,
    input  logic              rc_take,
    input  logic [PORT_W-1:0] rc_port,
    input  logic              va_gnt,
    input  logic [OVC_W-1:0]  va_ovc,
    input  logic              sa_gnt,
    output logic              rc_want,
    output logic              va_req,
    output logic              sa_req,
    output logic              pop,
    output logic [PORT_W-1:0] port,
    output logic [OVC_W-1:0]  ovc
);
    typedef struct packed {
        vc_state_e         st;
        logic [PORT_W-1:0] port;
        logic [OVC_W-1:0]  ovc;
    } vc_rec_t;

    vc_rec_t s_d, s_q;

    assign rc_want = (s_q.st == VC_ROUTE);
    assign va_req  = (s_q.st == VC_VALLOC);
    assign sa_req  = (s_q.st == VC_ACTIVE) && front_valid;
    assign pop     = sa_req && sa_gnt;
    assign port    = s_q.port;
    assign ovc     = s_q.ovc;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            VC_IDLE:   if (front_valid && front_head) s_d.st = VC_ROUTE;
            VC_ROUTE:  if (rc_take) begin
                           s_d.port = rc_port;
                           s_d.st   = VC_VALLOC;
                       end
            VC_VALLOC: if (va_gnt) begin
                           s_d.ovc = va_ovc;
                           s_d.st  = VC_ACTIVE;
                       end
            VC_ACTIVE: if (pop && front_tail) s_d.st = VC_IDLE;
            default:   s_d.st = VC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: VC_IDLE, port: '0, ovc: '0};
        else        s_q <= s_d;
    end

    // R5: an ungranted VC request stays up with an unchanged port
    a_r5_va_held: assert property (@(posedge clk) disable iff (!rst_n)
        va_req && !va_gnt |=> va_req && $stable(s_q.port));
    // R4: a VC request only starts after a route was accepted
    a_r4_route_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(va_req) |-> $past(rc_take));
    // R8: after the tail leaves the channel asks for nothing further
    a_r8_tail_release: assert property (@(posedge clk) disable iff (!rst_n)
        pop && front_tail |=> !sa_req && !va_req);
endmodule

// File: rtl/vcin_out_stage.sv
module vcin_out_stage #(
    parameter int NUM_VC = 2,
    parameter int DATA_W = 8,
    parameter int PORT_W = 2,
    parameter int OVC_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_VC-1:0]        pop,
    input  logic [NUM_VC*(DATA_W+2)-1:0] flits,
    input  logic [NUM_VC*PORT_W-1:0] ports,
    input  logic [NUM_VC*OVC_W-1:0]  ovcs,
    output logic                     out_valid,
    output logic                     out_head,
    output logic                     out_tail,
    output logic [DATA_W-1:0]        out_data,
    output logic [PORT_W-1:0]        out_port,
    output logic [OVC_W-1:0]         out_ovc
);
    localparam int FW = DATA_W + 2;

    typedef struct packed {
        logic              valid;
        logic              head;
        logic              tail;
        logic [DATA_W-1:0] data;
        logic [PORT_W-1:0] port;
        logic [OVC_W-1:0]  ovc;
    } out_reg_t;

    out_reg_t s_d, s_q;

    always_comb begin
        s_d = '0;
        for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (pop[v]) begin
                s_d.valid = 1'b1;
                s_d.head  = flits[v*FW + FW - 1];
                s_d.tail  = flits[v*FW + FW - 2];
                s_d.data  = flits[v*FW +: DATA_W];
                s_d.port  = ports[v*PORT_W +: PORT_W];
                s_d.ovc   = ovcs[v*OVC_W +: OVC_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.valid;
    assign out_head  = s_q.head;
    assign out_tail  = s_q.tail;
    assign out_data  = s_q.data;
    assign out_port  = s_q.port;
    assign out_ovc   = s_q.ovc;
endmodule

// File: rtl/vc_input_unit.sv
module vc_input_unit #(
    parameter int NUM_VC = 2,
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    parameter int PORT_W = 2,
    parameter int OVC_W  = 2,
    localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [VC_W-1:0]          in_vc,
    input  logic                     in_head,
    input  logic                     in_tail,
    input  logic [DATA_W-1:0]        in_data,
    output logic [NUM_VC-1:0]        in_full,
    output logic                     in_err,
    output logic                     rc_req_valid,
    output logic [VC_W-1:0]          rc_req_vc,
    output logic [DATA_W-1:0]        rc_req_hdr,
    input  logic                     rc_rsp_ready,
    input  logic [PORT_W-1:0]        rc_rsp_port,
    output logic [NUM_VC-1:0]        va_req,
    output logic [NUM_VC*PORT_W-1:0] va_port,
    input  logic [NUM_VC-1:0]        va_gnt,
    input  logic [OVC_W-1:0]         va_gnt_ovc,
    output logic [NUM_VC-1:0]        sa_req,
    input  logic [NUM_VC-1:0]        sa_gnt,
    output logic                     out_valid,
    output logic                     out_head,
    output logic                     out_tail,
    output logic [DATA_W-1:0]        out_data,
    output logic [PORT_W-1:0]        out_port,
    output logic [OVC_W-1:0]         out_ovc
);
    localparam int FW = DATA_W + 2;

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [NUM_VC-1:0]        push, pop, empty, rc_want, rc_take;
    logic [NUM_VC*FW-1:0]     front_flat;
    logic [NUM_VC*OVC_W-1:0]  ovc_flat;
    logic [VC_W-1:0]          rc_sel;

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        logic [FW-1:0] front;

        assign push[g] = in_valid && (in_vc == VC_W'(g)) && !in_full[g];
        assign front_flat[g*FW +: FW] = front;

        vcin_fifo #(.W(FW), .DEPTH(DEPTH)) u_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[g]),
            .wdata ({in_head, in_tail, in_data}),
            .pop   (pop[g]),
            .rdata (front),
            .full  (in_full[g]),
            .empty (empty[g])
        );

        vcin_vc_ctrl #(.PORT_W(PORT_W), .OVC_W(OVC_W)) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .front_valid (!empty[g]),
            .front_head  (front[FW-1]),
            .front_tail  (front[FW-2]),
            .rc_take     (rc_take[g]),
            .rc_port     (rc_rsp_port),
            .va_gnt      (va_gnt[g]),
            .va_ovc      (va_gnt_ovc),
            .sa_gnt      (sa_gnt[g]),
            .rc_want     (rc_want[g]),
            .va_req      (va_req[g]),
            .sa_req      (sa_req[g]),
            .pop         (pop[g]),
            .port        (va_port[g*PORT_W +: PORT_W]),
            .ovc         (ovc_flat[g*OVC_W +: OVC_W])
        );
    end

    // Shared route port: lowest-index channel in the routing phase wins.
    always_comb begin
        rc_sel     = '0;
        rc_req_hdr = '0;
        for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (rc_want[v]) begin
                rc_sel     = VC_W'(v);
                rc_req_hdr = front_flat[v*FW +: DATA_W];
            end
        end
        for (int v = 0; v < NUM_VC; v++) begin
            rc_take[v] = rc_want[v] && rc_rsp_ready && (rc_sel == VC_W'(v));
        end
    end

    assign rc_req_valid = |rc_want;
    assign rc_req_vc    = rc_sel;

    always_comb begin
        s_d.err = in_valid && in_full[in_vc];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_err = s_q.err;

    vcin_out_stage #(
        .NUM_VC(NUM_VC), .DATA_W(DATA_W), .PORT_W(PORT_W), .OVC_W(OVC_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (pop),
        .flits     (front_flat),
        .ports     (va_port),
        .ovcs      (ovc_flat),
        .out_valid (out_valid),
        .out_head  (out_head),
        .out_tail  (out_tail),
        .out_data  (out_data),
        .out_port  (out_port),
        .out_ovc   (out_ovc)
    );

    // R3: the error flag only follows a write aimed at a full channel
    a_r3_err_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        in_err |-> $past(in_valid && in_full[in_vc]));
    // R7: an outgoing flit follows an accepted switch grant
    a_r7_out_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(|(sa_gnt & sa_req)));
    // R7: the switch grants at most one channel per cycle
    a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sa_gnt));
endmodule

// File: tb/sim_vc_input_unit.sv
`timescale 1ns/1ps
module sim_vc_input_unit;
    localparam int NV = 2, DEPTH = 4, DATA_W = 8, PORT_W = 2, OVC_W = 2;
    localparam int VC_W = 1, FW = DATA_W + 2;

    logic clk = 0, rst_n = 0;
    always #2 clk = ~clk;

    logic in_valid = 0, in_head = 0, in_tail = 0;
    logic [VC_W-1:0] in_vc = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic [NV-1:0] in_full, va_req, va_gnt, sa_req, sa_gnt;
    logic in_err, rc_req_valid, rc_rsp_ready, out_valid, out_head, out_tail;
    logic [VC_W-1:0] rc_req_vc;
    logic [DATA_W-1:0] rc_req_hdr, out_data;
    logic [PORT_W-1:0] rc_rsp_port, out_port;
    logic [NV*PORT_W-1:0] va_port;
    logic [OVC_W-1:0] va_gnt_ovc, out_ovc;

    logic rc_en = 1;
    logic [NV-1:0] va_en = '1, sa_en = '1;
    logic [OVC_W-1:0] ovc_ctr = '0;

    function automatic logic [NV-1:0] grant_low(input logic [NV-1:0] r, input logic [NV-1:0] e);
        logic [NV-1:0] g = '0;
        for (int v = NV - 1; v >= 0; v--) if (r[v] && e[v]) g = NV'(1) << v;
        return g;
    endfunction

    assign rc_rsp_ready = rc_en;
    assign rc_rsp_port  = rc_req_hdr[PORT_W-1:0];
    assign va_gnt       = grant_low(va_req, va_en);
    assign va_gnt_ovc   = ovc_ctr;
    assign sa_gnt       = grant_low(sa_req, sa_en);

    vc_input_unit #(.NUM_VC(NV), .DEPTH(DEPTH), .DATA_W(DATA_W),
                    .PORT_W(PORT_W), .OVC_W(OVC_W)) u0 (.*);

    int n_chk = 0, n_err = 0, n_out = 0, n_tail = 0, n_rc = 0, n_heads = 0, n_pkts = 0;

    // behavioural reference state
    logic [FW-1:0] mq [NV][$];
    int mst [NV];
    logic [PORT_W-1:0] mpt [NV];
    logic [OVC_W-1:0] mov [NV];
    logic m_err = 0, mo_valid = 0, mo_head = 0, mo_tail = 0;
    logic [DATA_W-1:0] mo_data = '0;
    logic [PORT_W-1:0] mo_port = '0;
    logic [OVC_W-1:0] mo_ovc = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        logic [NV-1:0] mfull, m_va_req, m_sa_req, m_va_gnt, m_sa_gnt;
        int rcv, ost [NV];
        logic [FW-1:0] f;
        #1;
        rcv = -1;
        for (int v = 0; v < NV; v++) begin
            mfull[v]    = (mq[v].size() == DEPTH);
            m_va_req[v] = (mst[v] == 2);
            m_sa_req[v] = (mst[v] == 3) && (mq[v].size() > 0);
            ost[v]      = mst[v];
        end
        for (int v = NV - 1; v >= 0; v--) if (mst[v] == 1) rcv = v;
        m_va_gnt = grant_low(m_va_req, va_en);
        m_sa_gnt = grant_low(m_sa_req, sa_en);

        chk("R2 in_full", 32'(in_full), 32'(mfull));
        chk("R3 in_err", 32'(in_err), 32'(m_err));
        chk("R4 rc_req_valid", 32'(rc_req_valid), 32'(rcv >= 0));
        if (rcv >= 0) begin
            chk("R4 rc_req_vc", 32'(rc_req_vc), 32'(rcv));
            chk("R4 rc_req_hdr", 32'(rc_req_hdr), 32'(mq[rcv][0][DATA_W-1:0]));
        end
        chk("R5 va_req", 32'(va_req), 32'(m_va_req));
        for (int v = 0; v < NV; v++)
            if (m_va_req[v]) chk("R5 va_port", 32'(va_port[v*PORT_W +: PORT_W]), 32'(mpt[v]));
        chk("R6 sa_req", 32'(sa_req), 32'(m_sa_req));
        chk("R7 out_valid", 32'(out_valid), 32'(mo_valid));
        if (mo_valid) begin
            chk("R7 out_head", 32'(out_head), 32'(mo_head));
            chk("R7 out_tail", 32'(out_tail), 32'(mo_tail));
            chk("R7 out_data", 32'(out_data), 32'(mo_data));
            chk("R7 out_port", 32'(out_port), 32'(mo_port));
            chk("R7 out_ovc", 32'(out_ovc), 32'(mo_ovc));
        end
        if (out_valid) begin
            n_out++;
            if (out_tail) n_tail++;
        end
        if (rc_req_valid && rc_rsp_ready) n_rc++;

        mo_valid = 0;
        for (int v = 0; v < NV; v++) begin
            if (m_sa_gnt[v]) begin
                f = mq[v].pop_front();
                mo_valid = 1; mo_head = f[FW-1]; mo_tail = f[FW-2];
                mo_data = f[DATA_W-1:0]; mo_port = mpt[v]; mo_ovc = mov[v];
                if (mo_tail) mst[v] = 0;
            end
            if (m_va_gnt[v]) begin mov[v] = ovc_ctr; mst[v] = 3; end
            if (rcv == v && rc_en) begin mpt[v] = mq[v][0][PORT_W-1:0]; mst[v] = 2; end
            if (ost[v] == 0 && mq[v].size() > 0 && mq[v][0][FW-1]) mst[v] = 1;
            if (in_valid && in_vc == VC_W'(v) && !mfull[v])
                mq[v].push_back({in_head, in_tail, in_data});
        end
        m_err = in_valid && mfull[in_vc];
        @(posedge clk);
        @(negedge clk);
        if (|m_va_gnt) ovc_ctr = ovc_ctr + OVC_W'(1);
    endtask

    task automatic send(input int vc, input logic h, input logic t, input logic [DATA_W-1:0] d);
        in_valid = 1; in_vc = VC_W'(vc); in_head = h; in_tail = t; in_data = d;
        if (h) n_heads++;
        if (t) n_pkts++;
        step();
        in_valid = 0; in_head = 0; in_tail = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int n0;
        for (int v = 0; v < NV; v++) begin mst[v] = 0; mpt[v] = '0; mov[v] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        chk("R1 in_full", 32'(in_full), 0);
        chk("R1 in_err", 32'(in_err), 0);
        chk("R1 rc_req_valid", 32'(rc_req_valid), 0);
        chk("R1 va_req", 32'(va_req), 0);
        chk("R1 sa_req", 32'(sa_req), 0);
        chk("R1 out_valid", 32'(out_valid), 0);
        idle(1);

        // three-flit packet on channel 0
        send(0, 1, 0, 8'h12); send(0, 0, 0, 8'hA5); send(0, 0, 1, 8'h3C);
        idle(8);
        // single-flit packet on channel 1 (R8)
        send(1, 1, 1, 8'h47);
        idle(8);

        // fill channel 1 with the switch blocked (R2, R3)
        sa_en = '0;
        send(1, 1, 0, 8'h61); send(1, 0, 0, 8'h02); send(1, 0, 0, 8'h03); send(1, 0, 1, 8'h04);
        chk("R2 full at depth", 32'(in_full[1]), 1);
        send(1, 0, 0, 8'hEE);
        chk("R3 error pulse", 32'(in_err), 1);
        idle(1);
        chk("R3 error one cycle", 32'(in_err), 0);
        sa_en = '1;
        idle(10);

        // channel 0 stalled in VC allocation, channel 1 proceeds (R9)
        va_en = 2'b10;
        n0 = n_out;
        send(0, 1, 0, 8'h21); send(0, 0, 1, 8'h22);
        send(1, 1, 0, 8'h33); send(1, 0, 0, 8'h34); send(1, 0, 1, 8'h35);
        idle(12);
        chk("R9 other channel passes", 32'(n_out - n0), 3);
        va_en = '1;
        idle(10);
        chk("R9 stalled channel resumes", 32'(n_out - n0), 5);

        // both channels wait on a stalled route responder (R4)
        rc_en = 0;
        send(1, 1, 0, 8'h52); send(0, 1, 1, 8'h83); send(1, 0, 1, 8'h54);
        idle(3);
        rc_en = 1;
        idle(14);

        chk("R6 one route per head", 32'(n_rc), 32'(n_heads));
        chk("R8 every packet released", 32'(n_tail), 32'(n_pkts));
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule